// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software reach the registers of an Ethernet PHY over the two-wire management bus (MDC clock and bidirectional MDIO). It exposes two word-wide registers: a command register and a data register. For a write, software first loads the 16-bit value into the data register. It then writes the command register with the PHY address, the register number and the direction bit. For a read, only the command write is needed. After reading the busy flag back as zero, software finds the PHY's answer in the data register.

Each accepted command produces one complete 64-bit management frame. The frame is a 32-bit preamble of ones, the start pattern `01`, the opcode, the PHY address, the register number, a two-bit turnaround and sixteen data bits, all sent most significant bit first. MDC is derived from the system clock by a half-period parameter, so a 2.5 MHz ceiling can be met for any system clock. The MDIO pin is split into an output value, an output enable and an input, so that the pad can be placed outside the block.

Top module: `mdio_mgmt`

## Requirements
- R1: The command register (regAddr 0) reads back busy in bit 0, the direction (1 = write, 0 = read) in bit 1, the register number in bits 10:6 and the PHY address in bits 15:11, with all other bits zero. The data register (regAddr 1) reads back its 16-bit value in bits 15:0.
- R2: A command write while idle sets busy on the next cycle. Busy stays set for exactly 128 × DIV_HALF system cycles, which is 64 MDC periods, and then clears by itself.
- R3: A write frame is 32 ones, `01`, `01`, the PHY address, the register number, `10` and the data register value, MSB first, with MDIO driven for all 64 bits.
- R4: A read frame is 32 ones, `01`, `10`, the PHY address and the register number, driven for 46 bits. The block releases MDIO (output enable low) for the two turnaround bits and the 16 data bits, and whenever it is idle.
- R5: During a read, MDIO input is sampled on each rising MDC edge of the 16 data bits, and when busy clears the data register holds those bits, first-received in bit 15.
- R6: MDC is low while idle. During a frame it is low for DIV_HALF cycles and then high for DIV_HALF cycles per bit. MDIO output changes only when MDC falls or when a frame starts.
- R7: A command write while busy is ignored: the command fields and the frame in progress are unchanged.
- R8: A data-register write while busy is ignored: neither the value being sent nor the value read back changes.
- R9: While idle, a data-register write stores bits 15:0 and the value reads back unchanged after a write frame.
- R10: After reset both registers read zero, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 1 | Register select: 0 command, 1 data (for both read and write) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input value from the pad |

## Verification
The bench builds the block with DIV_HALF = 2, so one frame takes 256 cycles. This keeps all 64 bit positions of many frames, each with its exact busy length and MDC phase timing, within a short run. The small divider also gives the control and data writes made in the middle of a frame a definite place in the shifting sequence. The bench checks that the turnaround release and input sampling fall on the right MDC edges at the smallest divider where a low and a high phase both span more than one cycle.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = 6;
  localparam int FIELD_W    = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;   // first turnaround bit index
  localparam int DATA_FIRST = 48;   // first data bit index

  localparam int CTRL_BUSY_BIT = 0;
  localparam int CTRL_WR_BIT   = 1;
  localparam int CTRL_REG_LSB  = 6;
  localparam int CTRL_PHY_LSB  = 11;

  localparam logic REG_CTRL = 1'b0;
  localparam logic REG_DATA = 1'b1;

  localparam logic [1:0] SOF_PAT = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;

  typedef struct packed {
    logic load;     // latch command and build frame
    logic shift;    // advance to next frame bit
    logic capture;  // sample MDIO input into data register
    logic finish;   // frame complete
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic mdc,
  output logic riseTick,
  output logic fallTick
);
  localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF + 1);

  logic [CW-1:0] phaseCnt;
  logic          lastCnt;

  assign lastCnt  = (phaseCnt == CW'(DIV_HALF - 1));
  assign riseTick = run && lastCnt && !mdc;
  assign fallTick = run && lastCnt && mdc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      mdc      <= 1'b0;
    end else if (!run) begin
      phaseCnt <= '0;
      mdc      <= 1'b0;
    end else if (lastCnt) begin
      phaseCnt <= '0;
      mdc      <= ~mdc;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cmdWrite,
  input  logic             riseTick,
  input  logic             fallTick,
  output logic             busy,
  output logic [IDX_W-1:0] bitIdx,
  output logic             mdioOe,
  output mdioStrobe_t      strobe
);
  logic lastBit;

  assign lastBit = (bitIdx == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitIdx <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      bitIdx <= '0;
    end else if (busy && fallTick) begin
      if (lastBit) begin
        busy   <= 1'b0;
        bitIdx <= '0;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.load    = start;
    strobe.shift   = busy && fallTick && !lastBit;
    strobe.finish  = busy && fallTick && lastBit;
    strobe.capture = busy && riseTick && !cmdWrite &&
                     (bitIdx >= IDX_W'(DATA_FIRST));
  end

  // Reads release the line from the turnaround onwards.
  assign mdioOe = busy && (cmdWrite || (bitIdx < IDX_W'(TA_FIRST)));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  mdioStrobe_t        strobe,
  input  logic               busy,
  input  logic               regWrite,
  input  logic               regAddr,
  input  logic [31:0]        regWdata,
  input  logic               mdioIn,
  output logic [31:0]        regRdata,
  output logic               cmdWrite,
  output logic [FIELD_W-1:0] cmdPhy,
  output logic [FIELD_W-1:0] cmdReg,
  output logic               mdioOut
);
  logic [DATA_W-1:0]     dataReg;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] newFrame;
  logic                  newWrite;
  logic [FIELD_W-1:0]    newPhy;
  logic [FIELD_W-1:0]    newReg;

  assign newWrite = regWdata[CTRL_WR_BIT];
  assign newPhy   = regWdata[CTRL_PHY_LSB +: FIELD_W];
  assign newReg   = regWdata[CTRL_REG_LSB +: FIELD_W];

  always_comb begin
    if (newWrite)
      newFrame = {{PRE_BITS{1'b1}}, SOF_PAT, OP_WR, newPhy, newReg, TA_WR, dataReg};
    else
      newFrame = {{PRE_BITS{1'b1}}, SOF_PAT, OP_RD, newPhy, newReg, {(DATA_W+2){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWrite <= 1'b0;
      cmdPhy   <= '0;
      cmdReg   <= '0;
      shiftReg <= '0;
    end else if (strobe.load) begin
      cmdWrite <= newWrite;
      cmdPhy   <= newPhy;
      cmdReg   <= newReg;
      shiftReg <= newFrame;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      dataReg <= '0;
    else if (regWrite && (regAddr == REG_DATA) && !busy)
      dataReg <= regWdata[DATA_W-1:0];
    else if (strobe.capture)
      dataReg <= {dataReg[DATA_W-2:0], mdioIn};
  end

  assign mdioOut = shiftReg[FRAME_BITS-1];

  always_comb begin
    regRdata = '0;
    if (regAddr == REG_DATA) begin
      regRdata[DATA_W-1:0] = dataReg;
    end else begin
      regRdata[CTRL_BUSY_BIT]                 = busy;
      regRdata[CTRL_WR_BIT]                   = cmdWrite;
      regRdata[CTRL_REG_LSB +: FIELD_W]       = cmdReg;
      regRdata[CTRL_PHY_LSB +: FIELD_W]       = cmdPhy;
    end
  end
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_HALF = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrite,
  input  logic        regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobe_t        strobe;
  logic               busy;
  logic               start;
  logic               cmdWrite;
  logic [FIELD_W-1:0] cmdPhy;
  logic [FIELD_W-1:0] cmdReg;
  logic [IDX_W-1:0]   bitIdx;
  logic               riseTick;
  logic               fallTick;

  assign start = regWrite && (regAddr == REG_CTRL) && !busy;

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) clkDiv_i (
    .clk(clk), .rstN(rstN), .run(busy),
    .mdc(mdc), .riseTick(riseTick), .fallTick(fallTick)
  );

  mdio_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdWrite(cmdWrite),
    .riseTick(riseTick), .fallTick(fallTick),
    .busy(busy), .bitIdx(bitIdx), .mdioOe(mdioOe), .strobe(strobe)
  );

  mdio_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .mdioIn(mdioIn), .regRdata(regRdata), .cmdWrite(cmdWrite),
    .cmdPhy(cmdPhy), .cmdReg(cmdReg), .mdioOut(mdioOut)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_mgmt_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               regWrite,
  input logic               regAddr,
  input logic               mdc,
  input logic               mdioOe,
  input logic               cmdWrite,
  input logic [IDX_W-1:0]   bitIdx,
  input logic [FIELD_W-1:0] cmdPhy,
  input logic [FIELD_W-1:0] cmdReg
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && (regAddr == REG_CTRL) && !busy) |=> busy);

  p_idle_mdc_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  p_mdc_only_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdc) |-> $past(busy));

  p_idle_no_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

  p_read_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdWrite && (bitIdx >= IDX_W'(TA_FIRST))) |-> !mdioOe);

  p_write_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrite) |-> mdioOe);

  p_cmd_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrite && (regAddr == REG_CTRL)) |=>
      ($stable(cmdPhy) && $stable(cmdReg) && $stable(cmdWrite)));
endmodule

bind mdio_mgmt mdio_mgmt_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .regWrite(regWrite),
  .regAddr(regAddr), .mdc(mdc), .mdioOe(mdioOe), .cmdWrite(cmdWrite),
  .bitIdx(bitIdx), .cmdPhy(cmdPhy), .cmdReg(cmdReg)
);

// File: tb/mdio_mgmt_tb_top.sv
module mdio_mgmt_tb_top;
  localparam int DIV = 2;
  localparam int NVEC = 6;
  // {isWrite, phy, reg, data}: data is sent for writes, returned by the PHY for reads
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b1, 5'd1,  5'd0,  16'h1140},
    {1'b0, 5'd1,  5'd1,  16'h796D},
    {1'b1, 5'd31, 5'd31, 16'hFFFF},
    {1'b0, 5'd0,  5'd2,  16'h0000},
    {1'b1, 5'd0,  5'd0,  16'h0000},
    {1'b0, 5'd31, 5'd31, 16'hA5A5}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;

  // PHY model state
  logic        phyArm = 1'b0;
  int          riseCnt = 0;
  logic [63:0] seenBits = '0;
  logic [63:0] seenOe = '0;
  logic [15:0] phyReply = '0;

  always #5 clk = ~clk;

  mdio_mgmt #(.DIV_HALF(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc or posedge phyArm) begin
    if (phyArm) begin
      riseCnt = 0;
    end else begin
      if (riseCnt < 64) begin
        seenBits[63-riseCnt] = mdioOut;
        seenOe[63-riseCnt]   = mdioOe;
      end
      riseCnt = riseCnt + 1;
    end
  end

  always @(negedge mdc or posedge phyArm) begin
    if (phyArm) mdioIn = 1'b1;
    else if (riseCnt >= 48 && riseCnt < 64) mdioIn = phyReply[63-riseCnt];
    else mdioIn = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic regRd(input logic a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // Called right after regWr returns; counts falling edges with busy set.
  task automatic waitIdle(output int cyc);
    cyc = 0;
    regAddr = 1'b0;
    #1;
    while (regRdata[0]) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [63:0] expFrame(input logic w, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
    if (w) return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    else   return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h3FFFF};
  endfunction

  function automatic logic [31:0] ctrlWord(input logic w, input logic [4:0] p,
                                           input logic [4:0] r, input logic b);
    return {16'h0, p, r, 4'h0, w, b};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    longint t1, t2, t3;
    phyArm = 1'b1; #1 phyArm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R10 reset state
    regRd(1'b0, rd);
    chk(rd == 32'h0, "R10 ctrl after reset", rd, 0);
    regRd(1'b1, rd);
    chk(rd == 32'h0, "R10 data after reset", rd, 0);
    chk(mdc == 1'b0 && mdioOe == 1'b0, "R10 mdc/oe after reset", {mdc, mdioOe}, 0);

    // Table walk: R1 R2 R3 R4 R5 R9
    for (int i = 0; i < NVEC; i++) begin
      logic w; logic [4:0] p; logic [4:0] r; logic [15:0] d;
      logic [63:0] ef; logic [63:0] eo;
      {w, p, r, d} = VEC[i];
      if (w) begin
        regWr(1'b1, {16'hABCD, d});
        phyReply = 16'h0;
      end else begin
        phyReply = d;
      end
      phyArm = 1'b1; #1 phyArm = 1'b0;
      regWr(1'b0, ctrlWord(w, p, r, 1'b0));
      waitIdle(cyc);
      chk(cyc == 128 * DIV, "R2 busy length", cyc, 128 * DIV);
      regRd(1'b0, rd);
      chk(rd == ctrlWord(w, p, r, 1'b0), "R1 ctrl readback", rd, ctrlWord(w, p, r, 1'b0));
      ef = expFrame(w, p, r, d);
      eo = w ? 64'hFFFF_FFFF_FFFF_FFFF : {46'h3FFF_FFFF_FFFF, 18'h0};
      if (w) begin
        chk(seenBits == ef, "R3 write frame", seenBits, ef);
        chk(seenOe == eo, "R3 write drive", seenOe, eo);
        regRd(1'b1, rd);
        chk(rd == {16'h0, d}, "R9 data kept after write", rd, {16'h0, d});
      end else begin
        chk(seenBits[63:18] == ef[63:18], "R4 read frame header", seenBits, ef);
        chk(seenOe == eo, "R4 read release", seenOe, eo);
        regRd(1'b1, rd);
        chk(rd == {16'h0, d}, "R5 read data", rd, {16'h0, d});
      end
      chk(riseCnt == 64, "R2 64 mdc periods", riseCnt, 64);
    end

    // R6 MDC phase timing
    phyArm = 1'b1; #1 phyArm = 1'b0;
    regWr(1'b0, ctrlWord(1'b0, 5'd5, 5'd6, 1'b0));
    @(posedge mdc) t1 = $time;
    @(negedge mdc) t2 = $time;
    @(posedge mdc) t3 = $time;
    chk((t2 - t1) == DIV * 10, "R6 mdc high time", t2 - t1, DIV * 10);
    chk((t3 - t1) == 2 * DIV * 10, "R6 mdc period", t3 - t1, 2 * DIV * 10);
    @(negedge clk);
    waitIdle(cyc);
    repeat (3) @(negedge clk);
    chk(mdc == 1'b0 && mdioOe == 1'b0, "R6 idle mdc low", {mdc, mdioOe}, 0);

    // R7 / R8 writes while busy
    regWr(1'b1, 32'h0000_1234);
    phyArm = 1'b1; #1 phyArm = 1'b0;
    regWr(1'b0, ctrlWord(1'b1, 5'd3, 5'd4, 1'b0));
    repeat (10) @(negedge clk);
    regWr(1'b0, ctrlWord(1'b0, 5'd9, 5'd9, 1'b0));
    regRd(1'b0, rd);
    chk(rd == ctrlWord(1'b1, 5'd3, 5'd4, 1'b1), "R7 ctrl write ignored", rd,
        ctrlWord(1'b1, 5'd3, 5'd4, 1'b1));
    regWr(1'b1, 32'h0000_BEEF);
    waitIdle(cyc);
    chk(seenBits == expFrame(1'b1, 5'd3, 5'd4, 16'h1234), "R7 R8 frame unchanged",
        seenBits, expFrame(1'b1, 5'd3, 5'd4, 16'h1234));
    regRd(1'b1, rd);
    chk(rd == 32'h0000_1234, "R8 data write ignored", rd, 32'h1234);

    // R9 idle data write/readback
    regWr(1'b1, 32'hFFFF_5A3C);
    regRd(1'b1, rd);
    chk(rd == 32'h0000_5A3C, "R9 data readback", rd, 32'h5A3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule